// File: doc/BRIEF.md
# Limp-Home Device Mode Controller

This block is the device-level mode sequencer of an eight-channel low-side driver. It watches two supply-good flags, an enable pin and a limp-home pin, and moves the device between five modes: lockout, low-current sleep, global off, normal operation and limp-home. The modes drive a register reset, a write permission for the serial port, a transmission-error set pulse, a diagnostic-inhibit flag for power-up, and a limp-home override. The override hands channels 1 to 4 to the parallel pins and holds channels 5 to 8 off.

The enable and limp-home pins pass through a pulse-width filter before the sequencer uses them. A new pin level counts only after it has been stable for a set number of clock cycles. The supply flags come from comparators outside the block and act at once. In limp-home the serial port cannot write and the digital-supply flag is ignored. On leaving limp-home all registers are reset, and the enable level picks the next mode. The current mode is available as a one-hot output.

Top module: `limp_mode_ctrl`

## Requirements
- R1: `mode_oh` is one-hot in every cycle, using bit 0 lockout, bit 1 low-current, bit 2 global off, bit 3 normal, bit 4 limp-home. After reset the block is in lockout with `reg_reset`=1, `diag_inhibit`=1 and `ter_set`=0.
- R2: When `vdda_ok` is low, the next clock edge puts the block in lockout with `reg_reset` high, whatever the mode.
- R3: When `vdd_ok` is low, outside limp-home, the next edge puts the block in lockout. Inside limp-home `vdd_ok` has no effect.
- R4: An accepted high limp-home level with `vdda_ok` high enters limp-home whatever the enable level, even from lockout while `vdd_ok` is low. In limp-home `lh_override`=1, `lh_drive[3:0]` equals `par_in` (bit i is channel i+1) and `lh_drive[7:4]`=0. In every other mode `lh_drive` is 0.
- R5: `wr_en` is high only in global off and normal. A `cmd_valid` pulse during limp-home leaves the mode unchanged.
- R6: When the accepted limp-home level falls with both supplies good, the block leaves limp-home for one cycle of `reg_reset`. It goes to global off if the accepted enable is high, or to low-current if it is low, and in both cases `diag_inhibit`=1.
- R7: With limp-home low, an accepted low enable moves global off or normal to low-current, where `reg_reset` stays high. An accepted high enable moves low-current to global off with `diag_inhibit`=1.
- R8: `ter_set` is a one-cycle pulse on three transitions: lockout to any other mode, limp-home to global off or low-current, and low-current to global off. It is low on every other cycle, including limp-home to lockout and normal to low-current.
- R9: A pin level is accepted on the HOLD-th consecutive clock edge that samples it. A change that lasts fewer edges than HOLD is never accepted.
- R10: In global off, a `cmd_valid` pulse moves the block to normal and clears `diag_inhibit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vdda_ok | input | 1 | Analog supply above its reset threshold |
| vdd_ok | input | 1 | Digital supply above its reset threshold |
| en_pin | input | 1 | Enable pin, raw |
| lh_pin | input | 1 | Limp-home pin, raw |
| par_in | input | 4 | Parallel control pins for channels 1 to 4 |
| cmd_valid | input | 1 | Serial port latched a valid command frame |
| mode_oh | output | 5 | Current mode, one-hot |
| reg_reset | output | 1 | Reset for the input and fault registers |
| wr_en | output | 1 | Serial writes allowed |
| lh_override | output | 1 | Channel override active (limp-home) |
| lh_drive | output | 8 | Per-channel drive while the override is active |
| diag_inhibit | output | 1 | Open-load diagnostic current held off |
| ter_set | output | 1 | Pulse that sets the transmission-error flag |

## Verification
The assertions assume that `vdda_ok`, `vdd_ok`, `cmd_valid` and the raw pins are synchronous to `clk`. They also assume that `cmd_valid` comes from a serial port that only raises it while writes are allowed. The stimulus changes every input half a cycle away from the active edge. It holds `cmd_valid` for a single cycle, and raises it only in global off or in limp-home, where it must be ignored. Pin pulses are timed in whole cycles on both sides of the filter length. This places the acceptance edge, and the mode change one edge later, on a known cycle.

// File: rtl/limp_mode_pkg.sv
package limp_mode_pkg;
    localparam int unsigned M_LOCK = 0;
    localparam int unsigned M_SLEEP = 1;
    localparam int unsigned M_GOFF = 2;
    localparam int unsigned M_NORM = 3;
    localparam int unsigned M_LIMP = 4;
    localparam int unsigned N_MODES = 5;

    typedef logic [N_MODES-1:0] mode_oh_t;

    localparam mode_oh_t OH_LOCK  = mode_oh_t'(1) << M_LOCK;
    localparam mode_oh_t OH_SLEEP = mode_oh_t'(1) << M_SLEEP;
    localparam mode_oh_t OH_GOFF  = mode_oh_t'(1) << M_GOFF;
    localparam mode_oh_t OH_NORM  = mode_oh_t'(1) << M_NORM;
    localparam mode_oh_t OH_LIMP  = mode_oh_t'(1) << M_LIMP;

    typedef struct packed {
        mode_oh_t mode;
        logic     reg_rst;
        logic     ter;
        logic     diag_inh;
    } seq_regs_t;
endpackage

// File: rtl/lvl_filter.sv
module lvl_filter #(
    parameter int unsigned HOLD = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic lvl_o
);
    localparam int unsigned CW = (HOLD < 2) ? 1 : $clog2(HOLD);
    localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

    typedef struct packed {
        logic          lvl;
        logic [CW-1:0] cnt;
    } flt_t;

    flt_t flt_d, flt_q;

    always_comb begin
        flt_d = flt_q;
        if (raw_i == flt_q.lvl) begin
            flt_d.cnt = '0;
        end else if (flt_q.cnt == LAST) begin
            flt_d.lvl = raw_i;
            flt_d.cnt = '0;
        end else begin
            flt_d.cnt = flt_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flt_q <= '0;
        else        flt_q <= flt_d;
    end

    assign lvl_o = flt_q.lvl;

    // R9: an accepted level equals the level sampled on the edge that took it
    a_r9_flip_matches_pin: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(flt_q.lvl) |-> ($past(raw_i) == flt_q.lvl));

    // R9: the run-length counter never passes the hold length
    a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(flt_q.cnt) < HOLD));
endmodule

// File: rtl/mode_seq.sv
module mode_seq
    import limp_mode_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     vdda_ok,
    input  logic     vdd_ok,
    input  logic     en_f,
    input  logic     lh_f,
    input  logic     cmd_valid,
    output mode_oh_t mode_o,
    output logic     reg_rst_o,
    output logic     ter_o,
    output logic     diag_inh_o,
    output logic     wr_en_o
);
    seq_regs_t seq_d, seq_q;
    mode_oh_t  nxt;

    always_comb begin
        nxt = seq_q.mode;
        if (!vdda_ok)                  nxt = OH_LOCK;
        else if (lh_f)                 nxt = OH_LIMP;
        else if (!vdd_ok)              nxt = OH_LOCK;
        else if (seq_q.mode[M_LIMP] ||
                 seq_q.mode[M_LOCK] ||
                 seq_q.mode[M_SLEEP])  nxt = en_f ? OH_GOFF : OH_SLEEP;
        else if (!en_f)                nxt = OH_SLEEP;
        else if (seq_q.mode[M_GOFF] && cmd_valid) nxt = OH_NORM;

        seq_d.mode = nxt;
        seq_d.ter = (seq_q.mode[M_LOCK] && !nxt[M_LOCK]) ||
                    (seq_q.mode[M_LIMP] && (nxt[M_GOFF] || nxt[M_SLEEP])) ||
                    (seq_q.mode[M_SLEEP] && nxt[M_GOFF]);
        seq_d.reg_rst = nxt[M_LOCK] || nxt[M_SLEEP] ||
                        (seq_q.mode[M_LIMP] && !nxt[M_LIMP]);
        seq_d.diag_inh = nxt[M_LOCK] || nxt[M_SLEEP] ||
                         (nxt[M_GOFF] && !seq_q.mode[M_NORM]) ||
                         (nxt[M_GOFF] && seq_q.diag_inh);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.mode     <= OH_LOCK;
            seq_q.reg_rst  <= 1'b1;
            seq_q.ter      <= 1'b0;
            seq_q.diag_inh <= 1'b1;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign mode_o     = seq_q.mode;
    assign reg_rst_o  = seq_q.reg_rst;
    assign ter_o      = seq_q.ter;
    assign diag_inh_o = seq_q.diag_inh;
    assign wr_en_o    = seq_q.mode[M_GOFF] || seq_q.mode[M_NORM];

    a_r1_one_hot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(seq_q.mode) == 1);

    a_r2_analog_lockout: assert property (@(posedge clk) disable iff (!rst_n)
        !vdda_ok |=> (seq_q.mode[M_LOCK] && seq_q.reg_rst));

    a_r3_digital_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.mode[M_LIMP] && lh_f && vdda_ok) |=> seq_q.mode[M_LIMP]);

    a_r6_exit_resets: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.mode[M_LIMP] && !lh_f && vdda_ok && vdd_ok)
        |=> (seq_q.reg_rst && seq_q.ter && seq_q.diag_inh && !seq_q.mode[M_LIMP]));

    a_r10_go_normal: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.mode[M_GOFF] && cmd_valid && en_f && !lh_f && vdda_ok && vdd_ok)
        |=> (seq_q.mode[M_NORM] && !seq_q.diag_inh));
endmodule

// File: rtl/lh_drive_mux.sv
module lh_drive_mux #(
    parameter int unsigned N_PAR = 4,
    parameter int unsigned N_CH  = 8
) (
    input  logic             active_i,
    input  logic [N_PAR-1:0] par_i,
    output logic [N_CH-1:0]  drive_o
);
    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        if (c < N_PAR) begin : g_follow
            assign drive_o[c] = active_i && par_i[c];
        end else begin : g_off
            assign drive_o[c] = 1'b0;
        end
    end
endmodule

// File: rtl/limp_mode_ctrl.sv
module limp_mode_ctrl
    import limp_mode_pkg::*;
#(
    parameter int unsigned HOLD  = 8,
    parameter int unsigned N_PAR = 4,
    parameter int unsigned N_CH  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vdda_ok,
    input  logic             vdd_ok,
    input  logic             en_pin,
    input  logic             lh_pin,
    input  logic [N_PAR-1:0] par_in,
    input  logic             cmd_valid,
    output logic [4:0]       mode_oh,
    output logic             reg_reset,
    output logic             wr_en,
    output logic             lh_override,
    output logic [N_CH-1:0]  lh_drive,
    output logic             diag_inhibit,
    output logic             ter_set
);
    localparam int unsigned N_PINS = 2;

    logic [N_PINS-1:0] pins_raw, pins_acc;
    mode_oh_t          mode_w;

    assign pins_raw = {lh_pin, en_pin};

    for (genvar p = 0; p < N_PINS; p++) begin : g_pin
        lvl_filter #(.HOLD(HOLD)) u_flt (
            .clk   (clk),
            .rst_n (rst_n),
            .raw_i (pins_raw[p]),
            .lvl_o (pins_acc[p])
        );
    end

    mode_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .vdda_ok    (vdda_ok),
        .vdd_ok     (vdd_ok),
        .en_f       (pins_acc[0]),
        .lh_f       (pins_acc[1]),
        .cmd_valid  (cmd_valid),
        .mode_o     (mode_w),
        .reg_rst_o  (reg_reset),
        .ter_o      (ter_set),
        .diag_inh_o (diag_inhibit),
        .wr_en_o    (wr_en)
    );

    lh_drive_mux #(.N_PAR(N_PAR), .N_CH(N_CH)) u_mux (
        .active_i (mode_w[M_LIMP]),
        .par_i    (par_in),
        .drive_o  (lh_drive)
    );

    assign mode_oh     = mode_w;
    assign lh_override = mode_w[M_LIMP];

    // R5: a command arriving in limp-home never opens the write path next cycle
    a_r5_limp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (lh_override && cmd_valid && pins_acc[1] && vdda_ok) |=> !wr_en);
endmodule

// File: tb/tb_limp_mode_ctrl.sv
module tb_limp_mode_ctrl;
    localparam int unsigned HOLD = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       vdda_ok = 1'b0, vdd_ok = 1'b0, en_pin = 1'b0, lh_pin = 1'b0;
    logic [3:0] par_in = '0;
    logic       cmd_valid = 1'b0;
    logic [4:0] mode_oh;
    logic       reg_reset, wr_en, lh_override, diag_inhibit, ter_set;
    logic [7:0] lh_drive;

    limp_mode_ctrl #(.HOLD(HOLD)) dut (
        .clk(clk), .rst_n(rst_n), .vdda_ok(vdda_ok), .vdd_ok(vdd_ok),
        .en_pin(en_pin), .lh_pin(lh_pin), .par_in(par_in), .cmd_valid(cmd_valid),
        .mode_oh(mode_oh), .reg_reset(reg_reset), .wr_en(wr_en),
        .lh_override(lh_override), .lh_drive(lh_drive),
        .diag_inhibit(diag_inhibit), .ter_set(ter_set)
    );

    always #10 clk = ~clk;

    localparam logic [4:0] LOCK = 5'b00001, SLEEP = 5'b00010, GOFF = 5'b00100,
                           NORM = 5'b01000, LIMP = 5'b10000;

    typedef struct packed {
        logic [4:0] mode;
        logic       rr;
        logic       ter;
        logic       inh;
        logic       wr;
        logic       ovr;
        logic [7:0] drv;
    } obs_t;

    typedef struct {
        int    at;
        obs_t  exp;
        string tag;
    } item_t;

    item_t q[$];
    int    cyc = 0;
    int    checks = 0;
    int    failures = 0;
    bit    done = 1'b0;

    function automatic obs_t mk(logic [4:0] m, logic rr, logic ter, logic inh, logic [7:0] drv);
        obs_t o;
        o.mode = m; o.rr = rr; o.ter = ter; o.inh = inh;
        o.wr = (m == GOFF) || (m == NORM);
        o.ovr = (m == LIMP);
        o.drv = (m == LIMP) ? drv : 8'h00;
        return o;
    endfunction

    task automatic expect_after(int n, obs_t e, string tag);
        item_t it;
        it.at = cyc + n; it.exp = e; it.tag = tag;
        q.push_back(it);
        repeat (n) @(negedge clk);
    endtask

    // monitor: samples a quarter period after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            cyc++;
            while (q.size() > 0 && q[0].at == cyc) begin
                obs_t act;
                item_t it;
                it = q.pop_front();
                act = '{mode_oh, reg_reset, ter_set, diag_inhibit, wr_en, lh_override, lh_drive};
                checks++;
                if (act !== it.exp) begin
                    failures++;
                    $display("FAIL %s cyc=%0d actual=%h expected=%h", it.tag, cyc, act, it.exp);
                end
            end
        end
    end

    initial begin
        #(20 * 5000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        expect_after(1, mk(LOCK, 1, 0, 1, 0), "R1 reset state");
        // supplies good, enable low: lockout exit to sleep
        vdda_ok = 1; vdd_ok = 1;
        expect_after(1, mk(SLEEP, 1, 1, 1, 0), "R8 lockout exit pulse");
        expect_after(1, mk(SLEEP, 1, 0, 1, 0), "R8 pulse one cycle");
        // enable rises: accepted on the HOLD-th edge, mode one edge later
        en_pin = 1;
        expect_after(HOLD, mk(SLEEP, 1, 0, 1, 0), "R9 not yet accepted");
        expect_after(1, mk(GOFF, 0, 1, 1, 0), "R7 wake to global off");
        cmd_valid = 1;
        expect_after(1, mk(NORM, 0, 0, 0, 0), "R10 command to normal");
        cmd_valid = 0;
        // short limp-home pulse is ignored
        lh_pin = 1;
        expect_after(HOLD - 1, mk(NORM, 0, 0, 0, 0), "R9 short pulse");
        lh_pin = 0;
        expect_after(HOLD + 1, mk(NORM, 0, 0, 0, 0), "R9 short pulse ignored");
        // limp-home entry
        par_in = 4'b1010; lh_pin = 1;
        expect_after(HOLD, mk(NORM, 0, 0, 0, 0), "R4 drive off outside limp");
        expect_after(1, mk(LIMP, 0, 0, 0, 8'h0A), "R4 limp entry");
        vdd_ok = 0; cmd_valid = 1;
        expect_after(1, mk(LIMP, 0, 0, 0, 8'h0A), "R3 R5 vdd and command ignored");
        cmd_valid = 0; par_in = 4'b0101;
        expect_after(1, mk(LIMP, 0, 0, 0, 8'h05), "R4 drive follows pins");
        // exit with enable high
        vdd_ok = 1; lh_pin = 0;
        expect_after(HOLD, mk(LIMP, 0, 0, 0, 8'h05), "R9 exit pending");
        expect_after(1, mk(GOFF, 1, 1, 1, 0), "R6 exit to global off");
        expect_after(1, mk(GOFF, 0, 0, 1, 0), "R6 reset pulse one cycle");
        // re-enter, drop enable inside limp, exit to sleep
        lh_pin = 1;
        expect_after(HOLD + 1, mk(LIMP, 0, 0, 0, 8'h05), "R4 re-entry");
        en_pin = 0;
        expect_after(HOLD + 1, mk(LIMP, 0, 0, 0, 8'h05), "R4 enable ignored");
        lh_pin = 0;
        expect_after(HOLD + 1, mk(SLEEP, 1, 1, 1, 0), "R6 exit to sleep");
        expect_after(1, mk(SLEEP, 1, 0, 1, 0), "R8 pulse ends");
        vdd_ok = 0;
        expect_after(1, mk(LOCK, 1, 0, 1, 0), "R3 digital loss outside limp");
        lh_pin = 1;
        expect_after(HOLD + 1, mk(LIMP, 0, 1, 0, 8'h05), "R4 limp from lockout");
        vdda_ok = 0;
        expect_after(1, mk(LOCK, 1, 0, 1, 0), "R2 R8 analog loss in limp");
        vdda_ok = 1;
        expect_after(1, mk(LIMP, 0, 1, 0, 8'h05), "R4 back to limp");
        vdd_ok = 1; en_pin = 1; lh_pin = 0;
        expect_after(HOLD + 1, mk(GOFF, 1, 1, 1, 0), "R6 joint exit");
        en_pin = 0;
        expect_after(HOLD + 1, mk(SLEEP, 1, 0, 1, 0), "R7 R8 enable low to sleep");
        en_pin = 1;
        expect_after(HOLD + 1, mk(GOFF, 0, 1, 1, 0), "R8 sleep to global off");
        cmd_valid = 1;
        expect_after(1, mk(NORM, 0, 0, 0, 0), "R10 second command");
        cmd_valid = 0;
        vdda_ok = 0;
        expect_after(1, mk(LOCK, 1, 0, 1, 0), "R2 analog loss from normal");
        expect_after(2, mk(LOCK, 1, 0, 1, 0), "R1 lockout held");
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule